// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Level Interrupts

This block manages eight general purpose pins behind a small register interface. Software picks, for each pin, whether it listens (input), drives both levels (push-pull) or only pulls low (open-drain). Each pin also has its own interrupt whose active level is high or low as software chooses. Toward the pad ring the block gives an output enable and an output value for each pin, and it takes in the raw pin level. A strap vector, captured while reset is held, hands pins 0 to 5 to an external LED source. The enabled pending bits are merged into a single interrupt line.

Pin levels pass through a two-flop synchronizer. Each pin's interrupt is a two-state machine: `IRQ_CLEAR` and `IRQ_PENDING`. The transition SET (`IRQ_CLEAR` to `IRQ_PENDING`) fires when the synchronized level of an input pin equals its active level and no clear is being written in that cycle. The transition ACK (`IRQ_PENDING` to `IRQ_CLEAR`) fires when software writes 1 to that pin's status bit. In every other case the state holds, so a pending bit stays sticky until it is acknowledged. Register writes take effect at the clock edge on which `wr_en` is high. Reads are combinational from `addr`.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every register reads 0: direction (all pins inputs), drive type, polarity (low-level trigger), enables and status. `irq` is 0.
- R2: A non-LED pin with direction bit 1 and drive-type bit 0 (push-pull) has `pad_oe` = 1 and `pad_out` equal to its data bit.
- R3: A non-LED pin with direction bit 1 and drive-type bit 1 (open-drain) has `pad_out` = 0 and `pad_oe` = 1 when its data bit is 0. It has `pad_oe` = 0 when its data bit is 1.
- R4: A non-LED pin with direction bit 0 has `pad_oe` = 0 and `pad_out` = 0. Its bit in a DATA read returns the pin level two clock edges after the level is applied. Output pins read back their data bit.
- R5: An input pin whose synchronized level equals its active level sets its status bit on the third clock edge after the level is applied. The active level is high when the polarity bit is 1 and low when it is 0. A level held for two edges is captured.
- R6: A pin that is an output or in LED mode never sets its status bit, whatever its pad level. Detection resumes once the pin is an input again.
- R7: Status bits are sticky and are cleared by writing 1 to them at address 5. A clear wins over detection in the cycle it is written. If the pin is still active, the bit sets again on the next edge.
- R8: `irq` is the OR over all pins of status AND enable, combinationally. A masked status bit still reads back as 1.
- R9: `led_strap` is captured on each edge while `rst_n` is low and is frozen afterwards; later changes have no effect. A pin `i` (below 6) with a captured strap bit of 1 drives `pad_oe` = 1 and `pad_out` = `led_src[i]`, whatever its register settings. Its DATA read returns its data register bit.
- R10: Register map, where bit i is pin i: 0 DATA, 1 direction (1 = output), 2 drive type (1 = open-drain), 3 polarity, 4 enable, 5 status (write 1 to clear). Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data, bit i is pin i |
| rd_data | output | 8 | Combinational read data for `addr` |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| led_strap | input | 6 | LED-mode straps for pins 0 to 5, captured in reset |
| led_src | input | 6 | LED drive values for pins 0 to 5 |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The assertions assume that `led_strap` is steady in the last cycle of reset and that `pad_in` needs only the synchronizer, not a clean edge. The LED-stability and sticky-status properties are only valid under those assumptions. The bench changes every input on the falling clock edge, so the synchronizer never sees a level change near its sampling edge. It holds the strap constant until reset has been released for a cycle. Pad levels start high, which matches the synchronizer's reset value. As a result, no status bit sets on its own after reset before software has configured polarity.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register select; bit i of every register belongs to pin i
    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_ODRN = 3'd2,
        REG_POL  = 3'd3,
        REG_IEN  = 3'd4,
        REG_STS  = 3'd5
    } reg_sel_e;

    // Per-pin interrupt state
    typedef enum logic {
        IRQ_CLEAR   = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned    WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two-flop synchronizer; reset value matches the idle (pulled-up) pad level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic clr_i,
    output logic pend_o
);

    irq_state_e state_q;
    irq_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_CLEAR;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions: SET when active and not being cleared, ACK on write-1
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            IRQ_CLEAR: begin
                if (active_i && !clr_i) begin
                    state_nxt = IRQ_PENDING;
                end
            end
            IRQ_PENDING: begin
                if (clr_i) begin
                    state_nxt = IRQ_CLEAR;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend_o = (state_q == IRQ_PENDING);
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_ctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned NUM_LED  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [NUM_PINS-1:0] wr_data_i,
    input  logic [NUM_PINS-1:0] pin_sync_i,
    input  logic [NUM_PINS-1:0] in_mode_i,
    input  logic [NUM_PINS-1:0] sts_i,
    input  logic [NUM_LED-1:0]  led_strap_i,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] odrn_o,
    output logic [NUM_PINS-1:0] dat_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] ien_o,
    output logic [NUM_PINS-1:0] clr_o,
    output logic [NUM_LED-1:0]  led_mode_o,
    output logic [NUM_PINS-1:0] rd_data_o
);

    logic [NUM_PINS-1:0] dir_q, odrn_q, dat_q, pol_q, ien_q;
    logic [NUM_LED-1:0]  led_q;
    reg_sel_e            sel;

    assign sel = reg_sel_e'(addr_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            odrn_q <= '0;
            dat_q  <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
        end else if (wr_en_i) begin
            case (sel)
                REG_DATA: dat_q  <= wr_data_i;
                REG_DIR:  dir_q  <= wr_data_i;
                REG_ODRN: odrn_q <= wr_data_i;
                REG_POL:  pol_q  <= wr_data_i;
                REG_IEN:  ien_q  <= wr_data_i;
                default: ;
            endcase
        end
    end

    // Strap capture: reloaded on every edge in reset, frozen after release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= led_strap_i;
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_en_i && (sel == REG_STS)) begin
            clr_o = wr_data_i;
        end
    end

    always_comb begin
        case (sel)
            REG_DATA: rd_data_o = (in_mode_i & pin_sync_i) | (~in_mode_i & dat_q);
            REG_DIR:  rd_data_o = dir_q;
            REG_ODRN: rd_data_o = odrn_q;
            REG_POL:  rd_data_o = pol_q;
            REG_IEN:  rd_data_o = ien_q;
            REG_STS:  rd_data_o = sts_i;
            default:  rd_data_o = '0;
        endcase
    end

    assign dir_o      = dir_q;
    assign odrn_o     = odrn_q;
    assign dat_o      = dat_q;
    assign pol_o      = pol_q;
    assign ien_o      = ien_q;
    assign led_mode_o = led_q;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned NUM_LED  = 6
) (
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] odrn_i,
    input  logic [NUM_PINS-1:0] dat_i,
    input  logic [NUM_LED-1:0]  led_mode_i,
    input  logic [NUM_LED-1:0]  led_src_i,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] in_mode_o
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic led_sel;
        logic led_val;
        if (i < NUM_LED) begin : g_led
            assign led_sel = led_mode_i[i];
            assign led_val = led_src_i[i];
        end else begin : g_plain
            assign led_sel = 1'b0;
            assign led_val = 1'b0;
        end

        // LED override first, then output drive type, else input (undriven)
        assign pad_oe_o[i]  = led_sel ? 1'b1 :
                              dir_i[i] ? (odrn_i[i] ? ~dat_i[i] : 1'b1) : 1'b0;
        assign pad_out_o[i] = led_sel ? led_val :
                              (dir_i[i] && !odrn_i[i]) ? dat_i[i] : 1'b0;
        assign in_mode_o[i] = !led_sel && !dir_i[i];
    end

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
    import gpio_ctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned NUM_LED  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    input  logic [NUM_LED-1:0]  led_strap,
    input  logic [NUM_LED-1:0]  led_src,
    output logic                irq
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] dir_q, odrn_q, dat_q, pol_q, ien_q;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] sts;
    logic [NUM_PINS-1:0] in_mode;
    logic [NUM_PINS-1:0] active;
    logic [NUM_LED-1:0]  led_mode;

    gpio_sync #(
        .WIDTH   (NUM_PINS),
        .RST_VAL ({NUM_PINS{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (pin_sync)
    );

    gpio_regs #(
        .NUM_PINS (NUM_PINS),
        .NUM_LED  (NUM_LED)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wr_data_i   (wr_data),
        .pin_sync_i  (pin_sync),
        .in_mode_i   (in_mode),
        .sts_i       (sts),
        .led_strap_i (led_strap),
        .dir_o       (dir_q),
        .odrn_o      (odrn_q),
        .dat_o       (dat_q),
        .pol_o       (pol_q),
        .ien_o       (ien_q),
        .clr_o       (clr_mask),
        .led_mode_o  (led_mode),
        .rd_data_o   (rd_data)
    );

    gpio_pad_mux #(
        .NUM_PINS (NUM_PINS),
        .NUM_LED  (NUM_LED)
    ) u_mux (
        .dir_i      (dir_q),
        .odrn_i     (odrn_q),
        .dat_i      (dat_q),
        .led_mode_i (led_mode),
        .led_src_i  (led_src),
        .pad_oe_o   (pad_oe),
        .pad_out_o  (pad_out),
        .in_mode_o  (in_mode)
    );

    // Active level: synchronized pin equals polarity, input pins only
    assign active = in_mode & ~(pin_sync ^ pol_q);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_irq
        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active[i]),
            .clr_i    (clr_mask[i]),
            .pend_o   (sts[i])
        );
    end

    assign irq = |(sts & ien_q);

endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned NUM_LED  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          addr,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                irq,
    input logic [NUM_PINS-1:0] sts,
    input logic [NUM_PINS-1:0] ien,
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] odrn,
    input logic [NUM_PINS-1:0] in_mode,
    input logic [NUM_LED-1:0]  led_mode
);

    localparam int unsigned PAD_W = NUM_PINS - NUM_LED;

    logic [NUM_PINS-1:0] led_full;
    logic [NUM_PINS-1:0] clr_req;

    assign led_full = {{PAD_W{1'b0}}, led_mode};
    assign clr_req  = (wr_en && addr == 3'd5) ? wr_data : '0;

    // R3: an open-drain output never drives a high level
    a_r3_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir & odrn & ~led_full & pad_out) == '0));

    // R8: no enable, no interrupt
    a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R7: written ones clear their status bits on the next edge
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5) |=> ((sts & $past(wr_data)) == '0));

    // R7: a pending bit only drops when it is cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts) & ~$past(clr_req)) & ~sts) == '0));

    // R6: only pins that were inputs may newly set status
    a_r6_out_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts & ~$past(sts) & ~$past(in_mode)) == '0));

    // R9: captured strap does not move after reset
    a_r9_led_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(led_mode));

endmodule

bind gpio_ctl gpio_ctl_chk #(
    .NUM_PINS (NUM_PINS),
    .NUM_LED  (NUM_LED)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .pad_out  (pad_out),
    .irq      (irq),
    .sts      (sts),
    .ien      (ien_q),
    .dir      (dir_q),
    .odrn     (odrn_q),
    .in_mode  (in_mode),
    .led_mode (led_mode)
);

// File: tb/gpio_ctl_tb.sv
`timescale 1ns/1ps
module gpio_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [5:0] led_strap;
    logic [5:0] led_src;
    logic       irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    gpio_ctl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .led_strap (led_strap),
        .led_src   (led_src),
        .irq       (irq)
    );

    // {dir, odrn, data, exp_oe, exp_out, exp_rd}; pins 1:0 are LED pins here
    localparam logic [47:0] VECS [5] = '{
        48'hFF_00_A5_FF_A5_A5,
        48'hFF_FF_A5_5A_00_A5,
        48'h00_FF_FF_00_00_FF,
        48'hF0_30_5C_E0_40_5C,
        48'h0F_0C_C6_0B_02_F6
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst_n     = 1'b0;
        wr_en     = 1'b0;
        addr      = 3'd0;
        wr_data   = 8'h00;
        pad_in    = 8'hFF;
        led_strap = 6'b000011;
        led_src   = 6'b000000;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        led_strap = 6'b111111;   // R9: post-reset change must be ignored

        // R1 reset state
        rd(3'd1, r); check("R1 dir", r, 8'h00);
        rd(3'd2, r); check("R1 odrn", r, 8'h00);
        rd(3'd3, r); check("R1 pol", r, 8'h00);
        rd(3'd4, r); check("R1 ien", r, 8'h00);
        rd(3'd5, r); check("R1 sts", r, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pad_oe (LED pins only)", pad_oe, 8'h03);

        // R10 unused address
        wr(3'd6, 8'hFF);
        rd(3'd6, r); check("R10 unused reads 0", r, 8'h00);
        rd(3'd1, r); check("R10 unused write ignored", r, 8'h00);
        tick(2);

        // Vector table: R2 R3 R4
        for (int v = 0; v < 5; v++) begin
            wr(3'd1, VECS[v][47:40]);
            wr(3'd2, VECS[v][39:32]);
            wr(3'd0, VECS[v][31:24]);
            check("R2/R3/R4 pad_oe", pad_oe & 8'hFC, VECS[v][23:16] & 8'hFC);
            check("R2/R3/R4 pad_out", pad_out & 8'hFC, VECS[v][15:8] & 8'hFC);
            rd(3'd0, r); check("R4/R9 data read", r, VECS[v][7:0]);
        end
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd0, 8'hFF);

        // R4 input latency
        pad_in[2] = 1'b0;
        tick(1);
        rd(3'd0, r); check("R4 read one edge", r[2] ? 8'h01 : 8'h00, 8'h01);
        tick(1);
        rd(3'd0, r); check("R4 read two edges", r[2] ? 8'h01 : 8'h00, 8'h00);
        pad_in[2] = 1'b1;
        tick(3);
        wr(3'd5, 8'hFF);
        rd(3'd5, r); check("R7 clear all", r, 8'h00);

        // R5 two-cycle low pulse, pol 0
        wr(3'd4, 8'h04);
        pad_in[2] = 1'b0;
        tick(2);
        pad_in[2] = 1'b1;
        rd(3'd5, r); check("R5 not yet", r, 8'h00);
        tick(1);
        rd(3'd5, r); check("R5 low pulse captured", r, 8'h04);
        check("R8 irq enabled", {7'd0, irq}, 8'h01);
        tick(3);
        rd(3'd5, r); check("R7 sticky", r, 8'h04);
        wr(3'd5, 8'h04);
        rd(3'd5, r); check("R7 w1c", r, 8'h00);
        check("R8 irq after clear", {7'd0, irq}, 8'h00);

        // R7 clear while still active
        pad_in[2] = 1'b0;
        tick(3);
        wr(3'd5, 8'h04);
        rd(3'd5, r); check("R7 clear wins", r, 8'h00);
        tick(1);
        rd(3'd5, r); check("R7 re-set", r, 8'h04);
        pad_in[2] = 1'b1;
        tick(3);
        wr(3'd5, 8'h04);

        // R5 high polarity
        pad_in[3] = 1'b0;
        tick(3);
        wr(3'd3, 8'h08);
        wr(3'd5, 8'h08);
        tick(2);
        rd(3'd5, r); check("R5 low ignored with pol 1", r, 8'h00);
        pad_in[3] = 1'b1;
        tick(3);
        rd(3'd5, r); check("R5 high sets", r, 8'h08);
        check("R8 masked irq", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h08);
        check("R8 irq enable", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd5, 8'hFF);
        rd(3'd5, r); check("R7 clear", r, 8'h00);

        // R6 output and LED pins
        wr(3'd1, 8'h10);
        pad_in[4] = 1'b0;
        pad_in[0] = 1'b0;
        tick(4);
        rd(3'd5, r); check("R6 output/LED no set", r, 8'h00);
        wr(3'd1, 8'h00);
        tick(3);
        rd(3'd5, r); check("R6 input resumes", r, 8'h10);
        pad_in = 8'hFF;
        tick(3);
        wr(3'd5, 8'hFF);

        // R9 LED pins
        check("R9 strap frozen pad_oe", pad_oe, 8'h03);
        led_src = 6'b000010;
        #1;
        check("R9 led_src drives", pad_out, 8'h02);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h00);
        check("R9 LED override oe", pad_oe, 8'hFF);
        check("R9 LED override out", pad_out, 8'h02);
        rd(3'd0, r); check("R9 LED data read", r, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule